// File: doc/BRIEF.md
# Data-Dependent Early-Exit Vector Sequencer

This block steps through the elements of a vector operation strictly in order, from element 0 up to the vector length minus one. For every element whose predicate enable is high, it waits for the external datapath's result. From that result it forms a four-bit condition field holding less-than, greater-than, zero and overflow flags, then tests one selected bit of that field against a polarity control. The first failing test stops the loop. The failing element and every later one are dropped, and a shorter vector length is reported.

Software picks three things for each run. The first is which condition bit is tested and whether a set or a clear bit counts as failure. The second is whether condition fields are stored. The third is whether the operation acts only as a compare, so that results are never written back. When no condition store is requested, an inclusive option keeps the failing element inside the new length. The result of a run may be a length of zero. The arithmetic datapath and the register files lie outside this block. It drives commit strobes, an element index and a done pulse that carries the final length.

Top module: `ffvl_ctrl`

## Requirements
- R1: After reset, `issue`, `busy`, `done`, `res_commit` and `cr_commit` are low and `vl_out` is zero.
- R2: Elements are handled one at a time in ascending index order starting at 0, so commit strobes appear with strictly increasing `commit_idx` within a run.
- R3: The condition field is {lt, gt, eq, ov} in bits [3:0]. lt is set when the result is negative as a two's-complement value, gt when it is positive and nonzero, eq when it is zero, and ov copies `res_ov`.
- R4: `sel` picks the tested bit: 0 selects lt, 1 selects gt, 2 selects eq and 3 selects ov, which is field bit 3-`sel`. The test fails when that bit equals `inv`.
- R5: On the first failure at index k, with the inclusive option not in effect, the new length is k and no element at or above k has its result committed.
- R6: With `vli`=1 and `rc`=0, a failure at index k gives a new length of k+1, and the failing element's result is committed unless `rc1`=1.
- R7: With `rc`=1, `vli` has no effect and truncation always excludes the failing element.
- R8: If element 0 fails and the option is exclusive, the final length is 0 and no result is committed in that run.
- R9: With `rc1`=1 no element result is ever committed. The loop still ends at the first failure.
- R10: If no tested element fails, `vl_out` equals the requested length. A start with length 0 gives `done` in the following cycle with `vl_out`=0.
- R11: Elements whose `pred_en` is low are skipped without being tested. They receive no commit strobe and never cause truncation.
- R12: `done` pulses in the cycle after the last element is handled or the failure is detected. `busy` is low from that cycle on, and `vl_out` holds the final length.
- R13: When `rc` or `rc1` is set, every tested element, including the failing one, gets a `cr_commit` strobe with its condition field. Otherwise `cr_commit` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a run; accepted when not busy |
| vl_in | input | VL_W | Requested vector length |
| sel | input | 2 | Condition bit to test |
| inv | input | 1 | Value of the tested bit that counts as failure |
| rc | input | 1 | Store condition fields |
| rc1 | input | 1 | Compare-only: store condition fields, never results |
| vli | input | 1 | Inclusive truncation (effective only when rc=0) |
| pred_en | input | 1 | Predicate enable for the element at `elem_idx` |
| issue | output | 1 | Request to the datapath for element `elem_idx` |
| elem_idx | output | VL_W | Index of the current element |
| res_valid | input | 1 | Datapath result valid for `elem_idx` |
| res_data | input | DATA_W | Element result |
| res_ov | input | 1 | Element overflow/saturation flag |
| res_commit | output | 1 | Write back the result of element `commit_idx` |
| cr_commit | output | 1 | Write back the condition field of element `commit_idx` |
| commit_idx | output | VL_W | Element index for the commit strobes |
| cr_field | output | 4 | Condition field {lt,gt,eq,ov} |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| vl_out | output | VL_W | Final vector length, held until the next run ends |

## Verification
The assertions assume a few things about the environment. `start` is only raised while the block is idle. `pred_en` describes the element currently shown on `elem_idx`. `res_valid` is raised only while `issue` is high and applies to the element on `elem_idx`. The bench meets all three. Its datapath model answers only requests that have been issued, after a latency of zero to two cycles, and it derives the result, overflow flag and predicate purely from the element index and a per-run seed. Each run starts only after the previous `done`, and the bench then sweeps every length from 0 to 8 against all control combinations.

// File: rtl/ffvl_pkg.sv
package ffvl_pkg;

  typedef enum logic {
    FF_IDLE = 1'b0,
    FF_RUN  = 1'b1
  } ff_state_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic ov;
  } cond_t;

  // Build the condition field from sign, zero and overflow indications.
  function automatic cond_t form_cond(input logic neg, input logic zero, input logic ovf);
    cond_t c;
    c.lt = neg;
    c.gt = !neg && !zero;
    c.eq = zero;
    c.ov = ovf;
    return c;
  endfunction

  // Pick the tested bit; a failure is a bit equal to the polarity control.
  function automatic logic test_fails(input cond_t c, input logic [1:0] sel, input logic inv);
    logic b;
    case (sel)
      2'd0:    b = c.lt;
      2'd1:    b = c.gt;
      2'd2:    b = c.eq;
      default: b = c.ov;
    endcase
    return b == inv;
  endfunction

endpackage

// File: rtl/ffvl_cond.sv
module ffvl_cond
  import ffvl_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] res_data,
  input  logic              res_ov,
  input  logic [1:0]        sel,
  input  logic              inv,
  output cond_t             field,
  output logic              fail
);

  logic neg, zero;

  always_comb begin
    neg   = res_data[DATA_W-1];
    zero  = (res_data == '0);
    field = form_cond(neg, zero, res_ov);
    fail  = test_fails(field, sel, inv);
  end

  // R3
  always_comb begin
    if (!$isunknown(res_data)) begin
      cond_onehot_chk: assert ($onehot({field.lt, field.gt, field.eq}));
    end
  end

endmodule

// File: rtl/ffvl_seq.sv
module ffvl_seq
  import ffvl_pkg::*;
#(
  parameter int VL_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VL_W-1:0] vl_in,
  input  logic [1:0]      sel_in,
  input  logic            inv_in,
  input  logic            rc_in,
  input  logic            rc1_in,
  input  logic            vli_in,
  input  logic            pred_en,
  input  logic            res_valid,
  input  logic            test_fail,
  output logic [VL_W-1:0] idx,
  output logic            issue,
  output logic            busy,
  output logic            done,
  output logic [VL_W-1:0] vl_out,
  output logic [1:0]      sel_q,
  output logic            inv_q,
  output logic            rc_q,
  output logic            rc1_q,
  output logic            incl_q,
  output logic            eval_ev,
  output logic            fail_ev
);

  ff_state_e       st;
  logic [VL_W-1:0] vl_q;
  logic            trunc_q;
  logic            running, skip_ev, at_last, finish_ev, step_ev;

  function automatic logic [VL_W-1:0] cut_len(input logic [VL_W-1:0] at, input logic incl);
    return incl ? at + 1'b1 : at;
  endfunction

  always_comb begin
    running   = (st == FF_RUN);
    issue     = running && pred_en;
    skip_ev   = running && !pred_en;
    eval_ev   = issue && res_valid;
    fail_ev   = eval_ev && test_fail;
    at_last   = (idx == vl_q - 1'b1);
    finish_ev = (skip_ev && at_last) || (eval_ev && (test_fail || at_last));
    step_ev   = (skip_ev || eval_ev) && !finish_ev;
    busy      = running;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= FF_IDLE;
      idx     <= '0;
      vl_q    <= '0;
      vl_out  <= '0;
      done    <= 1'b0;
      trunc_q <= 1'b0;
      sel_q   <= '0;
      inv_q   <= 1'b0;
      rc_q    <= 1'b0;
      rc1_q   <= 1'b0;
      incl_q  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        FF_IDLE: begin
          if (start) begin
            sel_q   <= sel_in;
            inv_q   <= inv_in;
            rc_q    <= rc_in;
            rc1_q   <= rc1_in;
            incl_q  <= vli_in && !rc_in;
            vl_q    <= vl_in;
            idx     <= '0;
            trunc_q <= 1'b0;
            if (vl_in == '0) begin
              done   <= 1'b1;
              vl_out <= '0;
            end else begin
              st <= FF_RUN;
            end
          end
        end
        default: begin
          if (finish_ev) begin
            st      <= FF_IDLE;
            done    <= 1'b1;
            trunc_q <= fail_ev;
            vl_out  <= fail_ev ? cut_len(idx, incl_q) : vl_q;
          end else if (step_ev) begin
            idx <= idx + 1'b1;
          end
        end
      endcase
    end
  end

  // R2
  idx_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> (idx == $past(idx)) || (idx == $past(idx) + 1'b1));

  // R10
  vl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !trunc_q |-> vl_out == vl_q);

  // R5
  vl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> vl_out <= vl_q);

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R12
  finish_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

endmodule

// File: rtl/ffvl_commit.sv
module ffvl_commit
  import ffvl_pkg::*;
#(
  parameter int VL_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            eval_ev,
  input  logic            fail_ev,
  input  logic [VL_W-1:0] idx,
  input  cond_t           field,
  input  logic            rc_q,
  input  logic            rc1_q,
  input  logic            incl_q,
  output logic            res_commit,
  output logic            cr_commit,
  output logic [VL_W-1:0] commit_idx,
  output logic [3:0]      cr_field
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_commit <= 1'b0;
      cr_commit  <= 1'b0;
      commit_idx <= '0;
      cr_field   <= '0;
    end else begin
      res_commit <= eval_ev && !rc1_q && (!fail_ev || incl_q);
      cr_commit  <= eval_ev && (rc_q || rc1_q);
      if (eval_ev) begin
        commit_idx <= idx;
        cr_field   <= field;
      end
    end
  end

  // R9
  rc1_nores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_commit |-> !rc1_q);

  // R13
  cr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cr_commit |-> rc_q || rc1_q);

endmodule

// File: rtl/ffvl_ctrl.sv
module ffvl_ctrl
  import ffvl_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int DATA_W = 64,
  localparam int VL_W  = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VL_W-1:0]   vl_in,
  input  logic [1:0]        sel,
  input  logic              inv,
  input  logic              rc,
  input  logic              rc1,
  input  logic              vli,
  input  logic              pred_en,
  output logic              issue,
  output logic [VL_W-1:0]   elem_idx,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic              res_ov,
  output logic              res_commit,
  output logic              cr_commit,
  output logic [VL_W-1:0]   commit_idx,
  output logic [3:0]        cr_field,
  output logic              busy,
  output logic              done,
  output logic [VL_W-1:0]   vl_out
);

  cond_t      field;
  logic       test_fail;
  logic [1:0] sel_q;
  logic       inv_q, rc_q, rc1_q, incl_q;
  logic       eval_ev, fail_ev;

  ffvl_cond #(.DATA_W(DATA_W)) u_cond (
    .res_data (res_data),
    .res_ov   (res_ov),
    .sel      (sel_q),
    .inv      (inv_q),
    .field    (field),
    .fail     (test_fail)
  );

  ffvl_seq #(.VL_W(VL_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .vl_in     (vl_in),
    .sel_in    (sel),
    .inv_in    (inv),
    .rc_in     (rc),
    .rc1_in    (rc1),
    .vli_in    (vli),
    .pred_en   (pred_en),
    .res_valid (res_valid),
    .test_fail (test_fail),
    .idx       (elem_idx),
    .issue     (issue),
    .busy      (busy),
    .done      (done),
    .vl_out    (vl_out),
    .sel_q     (sel_q),
    .inv_q     (inv_q),
    .rc_q      (rc_q),
    .rc1_q     (rc1_q),
    .incl_q    (incl_q),
    .eval_ev   (eval_ev),
    .fail_ev   (fail_ev)
  );

  ffvl_commit #(.VL_W(VL_W)) u_commit (
    .clk        (clk),
    .rst_n      (rst_n),
    .eval_ev    (eval_ev),
    .fail_ev    (fail_ev),
    .idx        (elem_idx),
    .field      (field),
    .rc_q       (rc_q),
    .rc1_q      (rc1_q),
    .incl_q     (incl_q),
    .res_commit (res_commit),
    .cr_commit  (cr_commit),
    .commit_idx (commit_idx),
    .cr_field   (cr_field)
  );

  // R8
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && vl_out == '0 |-> !res_commit);

  // R6
  commit_in_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && res_commit |-> commit_idx < vl_out);

endmodule

// File: tb/tb_ffvl_ctrl.sv
module tb_ffvl_ctrl;

  localparam int MAXV = 8;
  localparam int DW   = 8;
  localparam int VW   = $clog2(MAXV + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [VW-1:0] vl_in = '0;
  logic [1:0]    sel = '0;
  logic          inv = 1'b0, rc = 1'b0, rc1 = 1'b0, vli = 1'b0;
  logic          pred_en;
  logic          issue;
  logic [VW-1:0] elem_idx;
  logic          res_valid = 1'b0;
  logic [DW-1:0] res_data;
  logic          res_ov;
  logic          res_commit, cr_commit, busy, done;
  logic [VW-1:0] commit_idx, vl_out;
  logic [3:0]    cr_field;

  int n_chk = 0, n_bad = 0;
  int cur_s = 0, cur_p = 0, lat = 0, wcnt = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] dat(int s, int i);
    logic [7:0] v;
    v = 8'((i * 53 + s * 29) ^ (s * 11));
    if ((i + s) % 5 == 0) v = 8'd0;
    return v;
  endfunction

  function automatic logic ovf(int s, int i);
    return ((i * 3 + s) % 4) == 0;
  endfunction

  function automatic logic enb(int p, int s, int i);
    return (p == 0) ? 1'b1 : (((i + s) % 4) != 3);
  endfunction

  // R3: expected field {lt,gt,eq,ov}
  function automatic logic [3:0] exp_fld(int s, int i);
    int sv;
    sv = int'($signed(dat(s, i)));
    return {sv < 0, sv > 0, sv == 0, ovf(s, i)};
  endfunction

  assign res_data = dat(cur_s, int'(elem_idx));
  assign res_ov   = ovf(cur_s, int'(elem_idx));
  assign pred_en  = enb(cur_p, cur_s, int'(elem_idx));

  ffvl_ctrl #(.MAX_VL(MAXV), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in), .sel(sel),
    .inv(inv), .rc(rc), .rc1(rc1), .vli(vli), .pred_en(pred_en),
    .issue(issue), .elem_idx(elem_idx), .res_valid(res_valid),
    .res_data(res_data), .res_ov(res_ov), .res_commit(res_commit),
    .cr_commit(cr_commit), .commit_idx(commit_idx), .cr_field(cr_field),
    .busy(busy), .done(done), .vl_out(vl_out)
  );

  // Datapath model: answers issued requests after lat cycles.
  always @(negedge clk) begin
    if (issue) begin
      if (wcnt >= lat) begin res_valid = 1'b1; wcnt = 0; end
      else begin res_valid = 1'b0; wcnt++; end
    end else begin
      res_valid = 1'b0;
      wcnt = 0;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_one(int vl, int sl, int iv, int r, int r1, int vi, int p);
    int f, expvl, last_h, limit, hi, prev_i;
    logic incl, fl, exp_dcr;
    logic [15:0] exp_res, exp_cr, got_res, got_cr;
    logic order_ok, fld_ok, dn_cr, dn_busy;
    logic [3:0] fe;
    int dn_idx;
    cur_p = p;
    cur_s = p * 13 + vl * 5 + sl * 3 + iv + 2 * r + 4 * r1 + 8 * vi;
    lat = (cur_s + vl) % 3;
    // expected outcome
    f = -1;
    for (int i = 0; i < vl; i++) begin
      if (enb(p, cur_s, i)) begin
        fe = exp_fld(cur_s, i);
        fl = (fe[3 - sl] == iv[0]);
        if (fl) begin f = i; break; end
      end
    end
    incl = (vi != 0) && (r == 0);
    expvl = (f < 0) ? vl : (incl ? f + 1 : f);
    hi = (f < 0) ? vl : f;
    exp_res = '0; exp_cr = '0;
    for (int i = 0; i < vl; i++) begin
      if (enb(p, cur_s, i)) begin
        if (r1 == 0 && (i < hi || (i == f && incl))) exp_res[i] = 1'b1;
        if ((r != 0 || r1 != 0) && (i < hi || i == f)) exp_cr[i] = 1'b1;
      end
    end
    last_h = (f < 0) ? vl - 1 : f;
    exp_dcr = (vl > 0) && (r != 0 || r1 != 0) && enb(p, cur_s, last_h);
    // drive
    vl_in = VW'(vl); sel = 2'(sl); inv = iv[0]; rc = r[0]; rc1 = r1[0]; vli = vi[0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got_res = '0; got_cr = '0; order_ok = 1'b1; fld_ok = 1'b1; prev_i = -1;
    dn_cr = 1'b0; dn_idx = -1; dn_busy = 1'b0;
    limit = 0;
    forever begin
      if (res_commit || cr_commit) begin
        if (int'(commit_idx) <= prev_i) order_ok = 1'b0;
        prev_i = int'(commit_idx);
      end
      if (res_commit) got_res[commit_idx] = 1'b1;
      if (cr_commit) begin
        got_cr[commit_idx] = 1'b1;
        if (cr_field != exp_fld(cur_s, int'(commit_idx))) fld_ok = 1'b0;
      end
      if (done) begin
        dn_cr = cr_commit; dn_idx = int'(commit_idx); dn_busy = busy;
        break;
      end
      limit++;
      if (limit > 100) break;
      @(negedge clk);
    end
    if (limit > 100) begin
      chk(1'b0, "R12 watchdog", limit, 100);
    end else begin
      chk(int'(vl_out) == expvl, "R5/R6/R7/R10 vl_out", int'(vl_out), expvl);
      chk(got_res == exp_res, "R9/R11/R8 result commits", int'(got_res), int'(exp_res));
      chk(got_cr == exp_cr, "R13 cond commits", int'(got_cr), int'(exp_cr));
      chk(fld_ok, "R3/R4 cond field", int'(fld_ok), 1);
      chk(order_ok, "R2 commit order", int'(order_ok), 1);
      chk(dn_cr == exp_dcr && (!exp_dcr || dn_idx == last_h),
          "R12 done timing", int'(dn_cr), int'(exp_dcr));
      chk(!dn_busy, "R12 busy at done", int'(dn_busy), 0);
      if (vl == 0) chk(limit == 0, "R10 zero-length latency", limit, 0);
    end
    @(negedge clk);
  endtask

  initial begin
    #(8 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!issue && !busy && !done, "R1 control outputs", int'({issue, busy, done}), 0);
    chk(!res_commit && !cr_commit, "R1 commit strobes", int'({res_commit, cr_commit}), 0);
    chk(vl_out == '0, "R1 vl_out", int'(vl_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int p = 0; p < 3; p++)
      for (int vl = 0; vl <= MAXV; vl++)
        for (int c = 0; c < 16; c++)
          for (int sl = 0; sl < 4; sl++)
            run_one(vl, sl, c & 1, (c >> 1) & 1, (c >> 2) & 1, (c >> 3) & 1, p);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule